// File: doc/BRIEF.md
# Cache Lockdown Victim Pointer Unit

This block chooses which line of a 64-way set-associative cache receives the next linefill. Lines can be locked so that they are never replaced. The cache is split into eight segments. The unit keeps one register set for the instruction cache and a separate one for the data cache. Each set holds a base pointer and one victim pointer per segment. Only indices from the base up to 63 can be chosen, so a base of 0 locks nothing and a base of 3 protects lines 0, 1 and 2.

Software reaches the unit through coprocessor-style register accesses. A 3-bit opcode field picks the cache and a 4-bit sub-register field picks the kind of write. The normal write loads the base pointer and every victim pointer of the chosen cache. A debug write loads only one segment's victim pointer and leaves the base alone. The cache controller raises a linefill request with a cache-select bit and a segment number. It gets the victim index back in the same cycle, and that segment's pointer advances at the next clock edge. The advance is either round-robin or taken from a free-running 6-bit pseudo-random sequence folded into the unlocked range.

Top module: `vp_lockdown_unit`

## Requirements
- R1: After reset, both caches read a base of 0, and every segment of both caches returns victim 0 on its first linefill.
- R2: `reg_op2` value 0 addresses the data-cache set and value 1 the instruction-cache set. A write with any other opcode value changes nothing, and a read with any other opcode value returns 0.
- R3: A write with `reg_crm` = 0 loads `reg_wdata[31:26]` into the base pointer and into all eight victim pointers of the addressed cache. The other cache is left untouched.
- R4: `reg_rdata` carries the addressed cache's base pointer in bits [31:26], and bits [25:0] are always 0.
- R5: While `fill_req` is high, `fill_victim` shows the addressed segment's current pointer in the same cycle. With `rr_mode` = 1 that pointer becomes the old value plus one at the next edge.
- R6: In round-robin mode, a pointer at 63 advances to the base pointer, not to 0.
- R7: A write with `reg_crm` = 1 loads `reg_wdata[31:26]` into the victim pointer of the segment given by `reg_wdata[7:5]` only. The base pointer and the other segments keep their values.
- R8: With `rr_mode` = 0, every victim returned lies between the base and 63 inclusive. With base 63 it is always 63.
- R9: If a write and a linefill reach the same cache in the same cycle, the written value wins, and the following linefill returns it. A linefill to the other cache in that cycle advances normally.
- R10: A write with `reg_crm` other than 0 or 1 changes neither the base nor any victim pointer.
- R11: A linefill advances only the addressed segment of the addressed cache.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_op2 | input | 3 | Cache select: 0 data, 1 instruction |
| reg_crm | input | 4 | Write kind: 0 base+all victims, 1 single victim |
| reg_wdata | input | 32 | Write data: value in [31:26], segment in [7:5] |
| reg_rdata | output | 32 | Base pointer of addressed cache in [31:26] |
| rr_mode | input | 1 | 1 round-robin advance, 0 pseudo-random advance |
| fill_req | input | 1 | Linefill request |
| fill_icache | input | 1 | 1 instruction cache, 0 data cache |
| fill_seg | input | 3 | Segment of the linefill |
| fill_victim | output | 6 | Victim index for the current request |

## Verification
The bench runs back-to-back round-robin linefills on one segment from a fresh base. It then seeds a pointer at 62 with a debug write so that the wrap lands on the base rather than on 0, and it checks that the other segments have not moved. Writes with mismatched opcode or sub-register values, and writes that collide with linefills to the same cache and to the other cache, separate correct decoding and priority from leaks between the two register sets. Long random-mode runs at base 40 check every returned index against the unlocked range and expect more than one distinct value. A run at base 63 leaves only one legal answer.

// File: rtl/vp_pkg.sv
package vp_pkg;
    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_BASE = 2'd1,
        WR_VIC  = 2'd2
    } wr_kind_e;
endpackage

// File: rtl/vp_lfsr.sv
module vp_lfsr #(
    parameter int          W    = 6,
    parameter logic [W-1:0] TAPS = 6'b110000,
    parameter logic [W-1:0] SEED = 6'b000001
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {lfsr_q[W-2:0], ^(lfsr_q & TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign value = lfsr_q;

    // random source must never lock up at zero (R8)
    assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
endmodule

// File: rtl/vp_advance.sv
module vp_advance #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] cur,
    input  logic [IDX_W-1:0] base,
    input  logic             rr_mode,
    input  logic [IDX_W-1:0] rnd,
    output logic [IDX_W-1:0] nxt
);
    localparam logic [IDX_W-1:0] MAXV = '1;
    localparam logic [IDX_W:0]   FULL = {1'b1, {IDX_W{1'b0}}};

    logic [IDX_W:0] span;
    logic [IDX_W:0] fold;
    logic [IDX_W:0] sum;

    always_comb begin
        span = FULL - {1'b0, base};
        fold = {1'b0, rnd} % span;
        sum  = {1'b0, base} + fold;
        if (rr_mode) begin
            nxt = (cur == MAXV) ? base : cur + {{(IDX_W-1){1'b0}}, 1'b1};
        end else if (rnd < base) begin
            nxt = sum[IDX_W-1:0];
        end else begin
            nxt = rnd;
        end
    end
endmodule

// File: rtl/vp_bank.sv
module vp_bank
    import vp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int SEG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_kind_e         wr_kind,
    input  logic [IDX_W-1:0] wr_val,
    input  logic [SEG_W-1:0] wr_seg,
    input  logic             fill_en,
    input  logic [SEG_W-1:0] fill_seg,
    input  logic             rr_mode,
    input  logic [IDX_W-1:0] rnd,
    output logic [IDX_W-1:0] base,
    output logic [IDX_W-1:0] victim
);
    localparam int             NSEG = 1 << SEG_W;
    localparam logic [IDX_W-1:0] MAXV = '1;

    typedef struct packed {
        logic [IDX_W-1:0]            base;
        logic [NSEG-1:0][IDX_W-1:0]  vic;
    } bank_t;

    bank_t            st_d, st_q;
    logic [IDX_W-1:0] cur_vic;
    logic [IDX_W-1:0] adv_val;

    assign cur_vic = st_q.vic[fill_seg];

    vp_advance #(.IDX_W(IDX_W)) u_adv (
        .cur     (cur_vic),
        .base    (st_q.base),
        .rr_mode (rr_mode),
        .rnd     (rnd),
        .nxt     (adv_val)
    );

    always_comb begin
        st_d = st_q;
        if (fill_en) st_d.vic[fill_seg] = adv_val;
        // writes applied last so they override a colliding linefill
        case (wr_kind)
            WR_BASE: begin
                st_d.base = wr_val;
                for (int s = 0; s < NSEG; s++) st_d.vic[s] = wr_val;
            end
            WR_VIC:  st_d.vic[wr_seg] = wr_val;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base   = st_q.base;
    assign victim = cur_vic;

    assert_base_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == WR_BASE) |=> (st_q.base == $past(wr_val)));

    assert_dbg_keeps_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == WR_VIC) |=> $stable(st_q.base));

    assert_rand_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !rr_mode) |-> (adv_val >= st_q.base));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en && wr_kind == WR_NONE) |=> $stable(st_q));

    for (genvar g = 0; g < NSEG; g++) begin : g_seg_chk
        assert_wrap_to_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_en && fill_seg == g && wr_kind == WR_NONE && rr_mode
             && st_q.vic[g] == MAXV) |=> (st_q.vic[g] == st_q.base));
        assert_all_vic_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_kind == WR_BASE) |=> (st_q.vic[g] == $past(wr_val)));
    end
endmodule

// File: rtl/vp_lockdown_unit.sv
module vp_lockdown_unit
    import vp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 6,
    parameter int SEG_W   = 3,
    parameter int OP2_W   = 3,
    parameter int CRM_W   = 4,
    parameter int SEG_LSB = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [OP2_W-1:0]  reg_op2,
    input  logic [CRM_W-1:0]  reg_crm,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rr_mode,
    input  logic              fill_req,
    input  logic              fill_icache,
    input  logic [SEG_W-1:0]  fill_seg,
    output logic [IDX_W-1:0]  fill_victim
);
    localparam int NCACHE = 2;   // index 0 data, 1 instruction

    logic [IDX_W-1:0] wr_val;
    logic [SEG_W-1:0] wr_seg;
    logic [IDX_W-1:0] rnd;
    logic [IDX_W-1:0] base_w   [NCACHE];
    logic [IDX_W-1:0] victim_w [NCACHE];
    wr_kind_e         kind_w   [NCACHE];

    assign wr_val = reg_wdata[DATA_W-1 -: IDX_W];
    assign wr_seg = reg_wdata[SEG_LSB +: SEG_W];

    vp_lfsr #(.W(IDX_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    for (genvar c = 0; c < NCACHE; c++) begin : g_cache
        always_comb begin
            kind_w[c] = WR_NONE;
            if (reg_wr && reg_op2 == OP2_W'(c)) begin
                if (reg_crm == CRM_W'(0))      kind_w[c] = WR_BASE;
                else if (reg_crm == CRM_W'(1)) kind_w[c] = WR_VIC;
            end
        end

        vp_bank #(.IDX_W(IDX_W), .SEG_W(SEG_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_kind  (kind_w[c]),
            .wr_val   (wr_val),
            .wr_seg   (wr_seg),
            .fill_en  (fill_req && (fill_icache == (c == 1))),
            .fill_seg (fill_seg),
            .rr_mode  (rr_mode),
            .rnd      (rnd),
            .base     (base_w[c]),
            .victim   (victim_w[c])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_op2 == OP2_W'(0))      reg_rdata[DATA_W-1 -: IDX_W] = base_w[0];
        else if (reg_op2 == OP2_W'(1)) reg_rdata[DATA_W-1 -: IDX_W] = base_w[1];
        fill_victim = fill_icache ? victim_w[1] : victim_w[0];
    end

    assert_rdata_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-IDX_W-1:0] == '0);

    assert_bad_op2_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_op2 > OP2_W'(1)) |=> ($stable(base_w[0]) && $stable(base_w[1])));
endmodule

// File: tb/vp_lockdown_unit_bench.sv
module vp_lockdown_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_op2 = '0;
    logic [3:0]  reg_crm = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rr_mode = 1'b1;
    logic        fill_req = 1'b0;
    logic        fill_icache = 1'b0;
    logic [2:0]  fill_seg = '0;
    logic [5:0]  fill_victim;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vp_lockdown_unit u_vp_lockdown_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_op2(reg_op2),
        .reg_crm(reg_crm), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rr_mode(rr_mode), .fill_req(fill_req), .fill_icache(fill_icache),
        .fill_seg(fill_seg), .fill_victim(fill_victim)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] val_word(logic [5:0] v, logic [2:0] seg);
        return {v, 18'd0, seg, 5'd0};
    endfunction

    task automatic reg_write(logic [2:0] op2, logic [3:0] crm, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_op2 = op2; reg_crm = crm; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(logic [2:0] op2, output logic [31:0] d);
        @(negedge clk);
        reg_op2 = op2;
        #1 d = reg_rdata;
    endtask

    task automatic fill(logic ic, logic [2:0] seg, output logic [5:0] v);
        @(negedge clk);
        fill_req = 1'b1; fill_icache = ic; fill_seg = seg;
        #1 v = fill_victim;
        @(negedge clk);
        fill_req = 1'b0;
    endtask

    task automatic test_reset();
        logic [31:0] d; logic [5:0] v;
        reg_read(3'd0, d); check("R1 dcache base", d, 32'h0);
        reg_read(3'd1, d); check("R1 icache base", d, 32'h0);
        fill(1'b0, 3'd4, v); check("R1 dcache victim", {26'd0, v}, 32'd0);
        fill(1'b1, 3'd6, v); check("R1 icache victim", {26'd0, v}, 32'd0);
    endtask

    task automatic test_round_robin();
        logic [31:0] d; logic [5:0] v;
        rr_mode = 1'b1;
        reg_write(3'd0, 4'd0, val_word(6'd3, 3'd0));
        reg_read(3'd0, d); check("R3/R4 dcache base read", d, {6'd3, 26'd0});
        reg_read(3'd1, d); check("R3 icache untouched", d, 32'h0);
        fill(1'b0, 3'd2, v); check("R5 first fill", {26'd0, v}, 32'd3);
        fill(1'b0, 3'd2, v); check("R5 second fill", {26'd0, v}, 32'd4);
        fill(1'b0, 3'd2, v); check("R5 third fill", {26'd0, v}, 32'd5);
        reg_write(3'd0, 4'd1, val_word(6'd62, 3'd2));
        reg_read(3'd0, d); check("R7 base kept", d, {6'd3, 26'd0});
        fill(1'b0, 3'd2, v); check("R7 seeded victim", {26'd0, v}, 32'd62);
        fill(1'b0, 3'd2, v); check("R6 at 63", {26'd0, v}, 32'd63);
        fill(1'b0, 3'd2, v); check("R6 wrap to base", {26'd0, v}, 32'd3);
        fill(1'b0, 3'd5, v); check("R11/R7 other seg", {26'd0, v}, 32'd3);
        fill(1'b0, 3'd2, v); check("R11 seg2 continues", {26'd0, v}, 32'd4);
    endtask

    task automatic test_select();
        logic [31:0] d; logic [5:0] v;
        reg_write(3'd1, 4'd0, val_word(6'd10, 3'd0));
        reg_read(3'd1, d); check("R2 icache base", d, {6'd10, 26'd0});
        reg_read(3'd0, d); check("R2 dcache kept", d, {6'd3, 26'd0});
        fill(1'b1, 3'd7, v); check("R2 icache victim", {26'd0, v}, 32'd10);
        fill(1'b0, 3'd2, v); check("R2 dcache seg2", {26'd0, v}, 32'd5);
        reg_write(3'd2, 4'd0, val_word(6'd20, 3'd0));
        reg_read(3'd0, d); check("R2 op2=2 no dcache", d, {6'd3, 26'd0});
        reg_read(3'd1, d); check("R2 op2=2 no icache", d, {6'd10, 26'd0});
        reg_read(3'd2, d); check("R2 op2=2 read zero", d, 32'h0);
        reg_write(3'd0, 4'd2, val_word(6'd50, 3'd0));
        reg_read(3'd0, d); check("R10 base kept", d, {6'd3, 26'd0});
        fill(1'b0, 3'd0, v); check("R10 victim kept", {26'd0, v}, 32'd3);
    endtask

    task automatic test_collision();
        logic [31:0] d; logic [5:0] v;
        @(negedge clk);
        reg_wr = 1'b1; reg_op2 = 3'd0; reg_crm = 4'd0; reg_wdata = val_word(6'd5, 3'd0);
        fill_req = 1'b1; fill_icache = 1'b0; fill_seg = 3'd0;
        @(negedge clk);
        reg_wr = 1'b0; fill_req = 1'b0;
        fill(1'b0, 3'd0, v); check("R9 write wins", {26'd0, v}, 32'd5);
        fill(1'b0, 3'd0, v); check("R9 then advances", {26'd0, v}, 32'd6);
        @(negedge clk);
        reg_wr = 1'b1; reg_op2 = 3'd0; reg_crm = 4'd0; reg_wdata = val_word(6'd8, 3'd0);
        fill_req = 1'b1; fill_icache = 1'b1; fill_seg = 3'd7;
        #1 check("R9 other cache victim", {26'd0, fill_victim}, 32'd11);
        @(negedge clk);
        reg_wr = 1'b0; fill_req = 1'b0;
        fill(1'b1, 3'd7, v); check("R9 other cache advanced", {26'd0, v}, 32'd12);
        reg_read(3'd0, d); check("R9 dcache base", d, {6'd8, 26'd0});
    endtask

    task automatic test_random();
        logic [5:0] v; logic [5:0] first; bit differ;
        reg_write(3'd1, 4'd0, val_word(6'd40, 3'd0));
        rr_mode = 1'b0;
        differ = 0;
        fill(1'b1, 3'd1, first);
        for (int i = 0; i < 60; i++) begin
            fill(1'b1, 3'd1, v);
            check("R8 in range base 40", {31'd0, (v >= 6'd40)}, 32'd1);
            if (v != first) differ = 1;
        end
        check("R8 values vary", {31'd0, differ}, 32'd1);
        reg_write(3'd1, 4'd0, val_word(6'd63, 3'd0));
        for (int i = 0; i < 8; i++) begin
            fill(1'b1, 3'd3, v); check("R8 base 63", {26'd0, v}, 32'd63);
        end
        rr_mode = 1'b1;
        fill(1'b1, 3'd3, v); check("R6 base 63 rr", {26'd0, v}, 32'd63);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_round_robin();
        test_select();
        test_collision();
        test_random();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule